// File: doc/BRIEF.md
# Partial-Array Temperature-Aware Refresh Scheduler

This block decides when a self-refreshing DRAM array, hidden behind an SRAM-like interface, refreshes its next row and which row that is. A free-running interval counter produces refresh ticks. Their spacing comes from a two-bit temperature ceiling: the hotter the ceiling, the shorter the spacing. Each tick refreshes one row taken from a coverage window. The window is the whole array, three quarters, one half, one quarter or nothing, and a direction bit pins it to the low or the high end of the row space. Rows outside the window are never refreshed.

An array access in flight (`access_busy`) holds a refresh back. The block remembers at most one held-back refresh and issues it as soon as the access ends. Deep power-down stops all refresh and drops `ready`. When deep power-down is released, or after reset, an initialization timer keeps `ready` low for a fixed time before normal accesses may resume. The asynchronous reset is released in step with the clock.

Top module: `rfsh_sched`

## Requirements
- R1: While reset is asserted and right after its release, `rf_strobe` and `ready` are 0.
- R2: Consecutive refresh strobes without a busy period are spaced by H×8, H×4, H×2 or H clock cycles for `temp_sel` codes 0, 1, 2 and 3 (15, 45, 70 and 85 degree ceilings), where H = CLK_MHZ×HOT_US.
- R3: `cov_sel` selects the window size: 0 full array, 1 half, 2 quarter, 3 none, 4 three quarters. The codes 5 to 7 act as full array.
- R4: With `cov_top` = 0 the window starts at row 0. With `cov_top` = 1 it ends at the highest row and starts at rows minus window size.
- R5: Strobed rows climb by one from the window start and wrap from the window end back to the window start, never leaving the window.
- R6: Any change of `cov_sel` or `cov_top` makes the next strobed row the start of the new window.
- R7: With coverage "none" no strobe is produced.
- R8: A tick that falls while `access_busy` is 1 is held. However many ticks pass during the busy period, exactly one strobe follows, in the clock cycle after the first cycle with `access_busy` low. No strobe is produced in the cycle after a busy cycle.
- R9: While `dpd_en` is 1 there is no strobe and `ready` is 0. Refresh resumes from the window start after release.
- R10: After `dpd_en` falls, `ready` stays 0 for CLK_MHZ×WAKE_US − 1 clock cycles and is 1 from cycle CLK_MHZ×WAKE_US on.
- R11: Each strobe carries its row on `rf_row` in the same cycle, one strobe per issued refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_sel | input | 2 | Temperature ceiling code (0 coolest, 3 hottest) |
| cov_sel | input | 3 | Coverage window size code |
| cov_top | input | 1 | Window anchor: 0 low end, 1 high end |
| dpd_en | input | 1 | Deep power-down enable |
| access_busy | input | 1 | Array access in progress; refresh must wait |
| rf_strobe | output | 1 | One refresh issued this cycle |
| rf_row | output | ROW_W | Row address for the refresh |
| ready | output | 1 | Initialization complete, accesses allowed |

## Verification
The properties assume that the settings inputs are synchronous to `clk` and that the busy and power-down inputs are registered signals with no glitches. They also assume the interval and wake parameters give at least two cycles per tick and at least one wake cycle. The bench changes every input on the falling clock edge. It changes coverage only right after an expected strobe has been consumed, and it parks coverage at "none" between phases, so no tick can land in a half-changed configuration. Busy and power-down periods start just after a strobe and span several intervals, which keeps the single held-back refresh clear of the next natural tick.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    T_COOL = 2'd0,
    T_MILD = 2'd1,
    T_WARM = 2'd2,
    T_HOT  = 2'd3
  } temp_e;

  typedef enum logic [2:0] {
    CV_ALL  = 3'd0,
    CV_HALF = 3'd1,
    CV_QTR  = 3'd2,
    CV_OFF  = 3'd3,
    CV_3QTR = 3'd4
  } cov_e;

endpackage

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned HOT_US  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] temp,
  output logic       tick
);
  import rfsh_pkg::*;

  localparam int unsigned HOT_CYC = CLK_MHZ * HOT_US;
  localparam int unsigned LIM_MAX = HOT_CYC * 8;
  localparam int unsigned CW      = $clog2(LIM_MAX + 1);

  logic [CW-1:0] cnt_q, cnt_d, lim;

  // Cooler ceilings stretch the interval by powers of two.
  always_comb begin
    case (temp)
      T_COOL:  lim = CW'(HOT_CYC * 8);
      T_MILD:  lim = CW'(HOT_CYC * 4);
      T_WARM:  lim = CW'(HOT_CYC * 2);
      default: lim = CW'(HOT_CYC);
    endcase
  end

  assign tick = run && (cnt_q >= lim - CW'(1));

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // A lower ceiling taken mid-count still resets within one cycle.
  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIM_MAX));

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/rfsh_window.sv
module rfsh_window #(
  parameter int unsigned ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cov,
  input  logic             top,
  input  logic             advance,
  input  logic             hold,
  output logic [ROW_W-1:0] row,
  output logic             nonempty,
  output logic             cfg_chg
);
  import rfsh_pkg::*;

  localparam int unsigned N  = 2 ** ROW_W;
  localparam int unsigned Q  = N / 4;
  localparam int unsigned SW = ROW_W + 1;

  logic [SW-1:0]    size, lo_w, hi_w;
  logic [ROW_W-1:0] lo, hi;
  logic [ROW_W-1:0] row_q, row_d;
  logic [3:0]       cfg_q;

  always_comb begin
    case (cov)
      CV_HALF: size = SW'(2 * Q);
      CV_QTR:  size = SW'(Q);
      CV_OFF:  size = '0;
      CV_3QTR: size = SW'(3 * Q);
      default: size = SW'(N);
    endcase
    lo_w = top ? (SW'(N) - size) : '0;
    hi_w = lo_w + size - SW'(1);
    lo   = lo_w[ROW_W-1:0];
    hi   = hi_w[ROW_W-1:0];
  end

  assign nonempty = (size != '0);
  assign cfg_chg  = ({cov, top} != cfg_q);
  assign row      = row_q;

  always_comb begin
    if (cfg_chg || hold) row_d = lo;
    else if (advance)    row_d = (row_q == hi) ? lo : row_q + ROW_W'(1);
    else                 row_d = row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      cfg_q <= '0;
    end else begin
      row_q <= row_d;
      cfg_q <= {cov, top};
    end
  end

  p_row_inside_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_chg && nonempty) |-> (row_q >= lo && row_q <= hi));

  p_wrap_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !cfg_chg && !hold && row_q == hi) |=> row_q == $past(lo));

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> row_q == $past(lo));

endmodule

// File: rtl/rfsh_wake.sv
module rfsh_wake #(
  parameter int unsigned WAKE_CYC = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dpd,
  output logic ready
);
  localparam int unsigned WW = $clog2(WAKE_CYC + 1);

  logic [WW-1:0] wcnt_q, wcnt_d;

  always_comb begin
    if (dpd)                wcnt_d = WW'(WAKE_CYC);
    else if (wcnt_q != '0)  wcnt_d = wcnt_q - WW'(1);
    else                    wcnt_d = wcnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= WW'(WAKE_CYC);
    else        wcnt_q <= wcnt_d;
  end

  assign ready = (wcnt_q == '0);

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dpd |=> !ready);

  p_wake_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dpd) |-> !ready);

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !dpd) |=> ready);

endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int unsigned ROW_W   = 8,
  parameter int unsigned CLK_MHZ = 50,
  parameter int unsigned HOT_US  = 8,
  parameter int unsigned WAKE_US = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       temp_sel,
  input  logic [2:0]       cov_sel,
  input  logic             cov_top,
  input  logic             dpd_en,
  input  logic             access_busy,
  output logic             rf_strobe,
  output logic [ROW_W-1:0] rf_row,
  output logic             ready
);
  localparam int unsigned WAKE_CYC = CLK_MHZ * WAKE_US;

  logic [1:0]       rs_q;
  logic             rst_s;
  logic             tick, want, issue, pend_q, pend_d;
  logic             nonempty, cfg_chg;
  logic [ROW_W-1:0] cur_row;
  logic             strobe_q;
  logic [ROW_W-1:0] row_q;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  rfsh_interval #(.CLK_MHZ(CLK_MHZ), .HOT_US(HOT_US)) u_intv (
    .clk(clk), .rst_n(rst_s), .run(!dpd_en), .temp(temp_sel), .tick(tick)
  );

  rfsh_window #(.ROW_W(ROW_W)) u_win (
    .clk(clk), .rst_n(rst_s), .cov(cov_sel), .top(cov_top),
    .advance(issue), .hold(dpd_en), .row(cur_row),
    .nonempty(nonempty), .cfg_chg(cfg_chg)
  );

  rfsh_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk(clk), .rst_n(rst_s), .dpd(dpd_en), .ready(ready)
  );

  // One held-back refresh at most; a window change or busy access defers it.
  always_comb begin
    want   = tick || pend_q;
    issue  = want && !access_busy && !cfg_chg && nonempty && !dpd_en;
    pend_d = want && !issue && nonempty && !dpd_en;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pend_q   <= 1'b0;
      strobe_q <= 1'b0;
      row_q    <= '0;
    end else begin
      pend_q   <= pend_d;
      strobe_q <= issue;
      if (issue) row_q <= cur_row;
    end
  end

  assign rf_strobe = strobe_q;
  assign rf_row    = row_q;

  p_busy_defer_r8: assert property (@(posedge clk) disable iff (!rst_s)
    access_busy |=> !rf_strobe);

  p_pend_cause_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(pend_q) |-> ($past(access_busy) || $past(cfg_chg)));

  p_dpd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_s)
    dpd_en |=> !rf_strobe);

  p_none_quiet_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (cov_sel == 3'd3) |=> !rf_strobe);

  p_row_follow_r11: assert property (@(posedge clk) disable iff (!rst_s)
    issue |=> (rf_strobe && rf_row == $past(cur_row)));

endmodule

// File: tb/rfsh_sched_tb.sv
module rfsh_sched_tb;

  localparam int ROW_W = 4;
  localparam int NROWS = 16;
  localparam int HOT   = 50;
  localparam int WAKE  = 100;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       temp_sel;
  logic [2:0]       cov_sel;
  logic             cov_top;
  logic             dpd_en;
  logic             access_busy;
  logic             rf_strobe;
  logic [ROW_W-1:0] rf_row;
  logic             ready;

  always #10 clk = ~clk;

  rfsh_sched #(.ROW_W(ROW_W), .CLK_MHZ(50), .HOT_US(1), .WAKE_US(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .temp_sel(temp_sel), .cov_sel(cov_sel),
    .cov_top(cov_top), .dpd_en(dpd_en), .access_busy(access_busy),
    .rf_strobe(rf_strobe), .rf_row(rf_row), .ready(ready)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  int    last_t = 0;
  int    prev_t = 0;
  int    n_strobe = 0;
  int    exp_q[$];
  string tag_q[$];

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Monitor: every strobe must match the next expected row.
  always @(negedge clk) begin
    if (rst_n && rf_strobe) begin
      n_strobe++;
      prev_t = last_t;
      last_t = cyc;
      if (exp_q.size() == 0) begin
        n_chk++;
        n_fail++;
        $display("FAIL unexpected strobe (R7, R8, R9) actual=%0d expected=none", rf_row);
      end else begin
        check(tag_q.pop_front(), int'(rf_row), exp_q.pop_front());
      end
    end
  end

  function automatic int win_size(input logic [2:0] c);
    case (c)
      3'd1:    return NROWS / 2;
      3'd2:    return NROWS / 4;
      3'd3:    return 0;
      3'd4:    return 3 * NROWS / 4;
      default: return NROWS;
    endcase
  endfunction

  function automatic int win_lo(input logic [2:0] c, input logic t);
    return t ? NROWS - win_size(c) : 0;
  endfunction

  function automatic int gap_for(input logic [1:0] t);
    return HOT << (3 - int'(t));
  endfunction

  task automatic push_rows(input logic [2:0] c, input logic t, input int first, input int n,
                           input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(win_lo(c, t) + ((first + i) % win_size(c)));
      tag_q.push_back(tag);
    end
  endtask

  task automatic park();
    @(negedge clk);
    cov_sel = 3'd3;
  endtask

  task automatic run_window(input logic [2:0] c, input logic t, input logic [1:0] tp,
                            input int n, input string tag, input bit gap_chk);
    @(negedge clk);
    temp_sel = tp;
    cov_sel  = c;
    cov_top  = t;
    push_rows(c, t, 0, n, tag);
    wait (exp_q.size() == 0);
    park();
    if (gap_chk) check({tag, " R2 spacing"}, last_t - prev_t, gap_for(tp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0; temp_sel = 2'd3; cov_sel = 3'd3; cov_top = 1'b0;
    dpd_en = 1'b0; access_busy = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", int'(rf_strobe), 0);
    check("R1 ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 ready after release", int'(ready), 0);
    check("R1 strobe after release", int'(rf_strobe), 0);
    wait (ready);

    // R3 R4 R5: every window, both anchors, with wrap
    run_window(3'd0, 1'b0, 2'd3, 18, "R5 full low wrap", 1'b1);
    run_window(3'd4, 1'b0, 2'd3, 14, "R3 three-quarter low", 1'b1);
    run_window(3'd4, 1'b1, 2'd3, 14, "R4 three-quarter high", 1'b1);
    run_window(3'd1, 1'b0, 2'd3, 10, "R3 half low", 1'b1);
    run_window(3'd1, 1'b1, 2'd3, 10, "R4 half high", 1'b1);
    run_window(3'd2, 1'b0, 2'd3, 6,  "R3 quarter low", 1'b1);
    run_window(3'd2, 1'b1, 2'd3, 6,  "R4 quarter high", 1'b1);
    run_window(3'd6, 1'b0, 2'd3, 3,  "R3 reserved code as full", 1'b1);

    // R2: cooler ceilings
    run_window(3'd2, 1'b1, 2'd2, 3, "R2 ceiling 70", 1'b1);
    run_window(3'd2, 1'b1, 2'd1, 3, "R2 ceiling 45", 1'b1);
    run_window(3'd2, 1'b1, 2'd0, 3, "R2 ceiling 15", 1'b1);

    // R6: window change mid-run restarts at the new start
    @(negedge clk);
    temp_sel = 2'd3; cov_sel = 3'd1; cov_top = 1'b0;
    push_rows(3'd1, 1'b0, 0, 3, "R6 before change");
    wait (exp_q.size() == 0);
    @(negedge clk);
    cov_top = 1'b1;
    push_rows(3'd1, 1'b1, 0, 2, "R6 after anchor flip");
    wait (exp_q.size() == 0);
    @(negedge clk);
    cov_sel = 3'd2;
    push_rows(3'd2, 1'b1, 0, 2, "R6 after size change");
    wait (exp_q.size() == 0);
    park();

    // R7: no coverage, no strobes
    base = n_strobe;
    repeat (300) @(negedge clk);
    check("R7 strobes with no coverage", n_strobe - base, 0);

    // R8: busy across several ticks gives a single deferred strobe
    @(negedge clk);
    cov_sel = 3'd0; cov_top = 1'b0;
    push_rows(3'd0, 1'b0, 0, 1, "R8 lead-in");
    wait (exp_q.size() == 0);
    @(negedge clk);
    access_busy = 1'b1;
    base = n_strobe;
    repeat (170) @(negedge clk);
    check("R8 strobes while busy", n_strobe - base, 0);
    push_rows(3'd0, 1'b0, 1, 1, "R8 deferred row");
    access_busy = 1'b0;
    @(negedge clk);
    check("R8 deferred strobe timing", int'(rf_strobe), 1);
    repeat (5) @(negedge clk);
    check("R8 single deferred strobe", n_strobe - base, 1);
    park();

    // R9 R10: power-down silences refresh, then timed wake
    @(negedge clk);
    cov_sel = 3'd0;
    push_rows(3'd0, 1'b0, 0, 1, "R9 lead-in");
    wait (exp_q.size() == 0);
    @(negedge clk);
    dpd_en = 1'b1;
    base = n_strobe;
    @(negedge clk);
    check("R9 ready in power-down", int'(ready), 0);
    repeat (300) @(negedge clk);
    check("R9 strobes in power-down", n_strobe - base, 0);
    cov_sel = 3'd3;
    @(negedge clk);
    dpd_en = 1'b0;
    repeat (WAKE - 1) @(negedge clk);
    check("R10 ready before wake time", int'(ready), 0);
    @(negedge clk);
    check("R10 ready at wake time", int'(ready), 1);
    run_window(3'd0, 1'b0, 2'd3, 2, "R9 resume from start", 1'b1);

    finish_run();
  end

endmodule